// File: doc/BRIEF.md
# Port interrupt-on-change detector

This block watches the upper half of an 8-bit input port and raises an interrupt request whenever one of the watched pins changes level. Each watched pin can be switched on or off on its own. A change on any switched-on pin sets one shared sticky change flag, which stays set until software clears it. The flag becomes an interrupt request only when a port-wide interrupt enable is also set. A priority bit then sends that request out either on the high-priority line or on the low-priority line.

The port inputs pass through a synchroniser. For each watched pin the block keeps the last level it saw. A pin counts as changed when its synchronised level differs from that stored level while the pin is switched on. When a pin is switched on, its stored level is loaded at the same moment, so switching a pin on never reports a change that has not happened. Software reaches the block through a small register port with two addresses: one holds the per-pin enables and one holds the flag, the port enable and the priority. Reads are combinational and writes take effect on the clock edge.

Top module: `port_change_irq`

## Requirements
- R1: Only port bits 7 down to 4 are watched. A level change on port bits 3 down to 0 never sets the change flag.
- R2: When a switched-on watched pin changes level, the change flag is set on the third rising clock edge after the new level is presented, counting two synchroniser stages and the flag register.
- R3: A level change on a watched pin whose enable is 0 leaves the change flag unchanged.
- R4: Address 0 is the per-pin enable register. Bits 7:4 enable pins 7:4 (1 means watched) and can be written and read back. Bits 3:0 always read as 0.
- R5: The change flag is read at address 1, bit 0. It stays set until a write to address 1 with bit 0 equal to 1 clears it. When such a write falls on the same edge as a new change, the flag stays set.
- R6: Address 1, bit 1 is the port-level interrupt enable. While it is 0, neither request line is asserted, even with the flag set.
- R7: Address 1, bit 2 selects the priority. While the flag and the port enable are both 1, a priority of 1 drives irq_hi and a priority of 0 drives irq_lo. The two lines are never high together.
- R8: When a pin is switched on while its level already differs from the level it had when it was last watched, no change is reported. The next real change on that pin is reported.
- R9: After reset, both registers read 0 and both request lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_in | input | 8 | Port pin levels, asynchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 = pin enables, 1 = control/status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| irq_hi | output | 1 | High-priority change interrupt request |
| irq_lo | output | 1 | Low-priority change interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit port with watched pins 7:4 and a two-stage synchroniser. With these values the three-edge latency in R2 can be checked exactly, and the R5 case, where a clear falls on the same edge as a new change, can be placed on that edge. Pins 3:0 in this build stay outside the watched range, so a toggle on them shows that they cannot set the flag.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  // Register select values
  localparam logic ADDR_PINEN = 1'b0;
  localparam logic ADDR_CTRL  = 1'b1;
  // Bit positions inside the control/status register
  localparam int CTRL_FLAG = 0;
  localparam int CTRL_ENA  = 1;
  localparam int CTRL_PRI  = 2;
  localparam int CTRL_USED = 3;
endpackage

// File: rtl/pcd_sync.sv
module pcd_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pcd_detect.sv
module pcd_detect #(
  parameter int MON_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MON_W-1:0] smp,
  input  logic [MON_W-1:0] en,
  input  logic [MON_W-1:0] load,
  output logic [MON_W-1:0] chg_vec,
  output logic             chg_any
);
  logic [MON_W-1:0] last_q;

  // Reference follows the sampled level on watched pins and is loaded on enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
    end else begin
      for (int b = 0; b < MON_W; b++)
        if (en[b] || load[b]) last_q[b] <= smp[b];
    end
  end

  for (genvar b = 0; b < MON_W; b++) begin : g_pin
    assign chg_vec[b] = en[b] & (smp[b] ^ last_q[b]);

    AST_REF_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      (en[b] || load[b]) |=> (last_q[b] == $past(smp[b]))); // R8
  end

  assign chg_any = |chg_vec;
endmodule

// File: rtl/pcd_regs.sv
module pcd_regs
  import pcd_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int MON_LO = 4,
  localparam int MON_W = PORT_W - MON_LO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [PORT_W-1:0] reg_wdata,
  output logic [PORT_W-1:0] reg_rdata,
  input  logic              chg_any,
  output logic [MON_W-1:0]  pin_en,
  output logic [MON_W-1:0]  pin_load,
  output logic              irq_hi,
  output logic              irq_lo
);
  logic flag_q, ena_q, pri_q;
  logic wr_pin, wr_ctl, clr;
  logic wdata_unused;

  assign wr_pin   = reg_wr && (reg_addr == ADDR_PINEN);
  assign wr_ctl   = reg_wr && (reg_addr == ADDR_CTRL);
  assign clr      = wr_ctl && reg_wdata[CTRL_FLAG];
  assign pin_load = wr_pin ? (reg_wdata[PORT_W-1:MON_LO] & ~pin_en) : '0;
  assign wdata_unused = ^reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_en <= '0;
      flag_q <= 1'b0;
      ena_q  <= 1'b0;
      pri_q  <= 1'b0;
    end else begin
      if (wr_pin) pin_en <= reg_wdata[PORT_W-1:MON_LO];
      if (wr_ctl) begin
        ena_q <= reg_wdata[CTRL_ENA];
        pri_q <= reg_wdata[CTRL_PRI];
      end
      // a new change outranks a clear on the same edge
      flag_q <= chg_any | (flag_q & ~clr);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_PINEN) begin
      reg_rdata[PORT_W-1:MON_LO] = pin_en;
    end else begin
      reg_rdata[CTRL_FLAG] = flag_q;
      reg_rdata[CTRL_ENA]  = ena_q;
      reg_rdata[CTRL_PRI]  = pri_q;
    end
  end

  assign irq_hi = flag_q & ena_q & pri_q;
  assign irq_lo = flag_q & ena_q & ~pri_q;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    chg_any |=> flag_q); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q); // R5
  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_PINEN) |-> (reg_rdata[MON_LO-1:0] == '0)); // R4
endmodule

// File: rtl/port_change_irq.sv
module port_change_irq #(
  parameter int PORT_W      = 8,
  parameter int MON_LO      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] port_in,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [PORT_W-1:0] reg_wdata,
  output logic [PORT_W-1:0] reg_rdata,
  output logic              irq_hi,
  output logic              irq_lo
);
  localparam int MON_W = PORT_W - MON_LO;

  logic [MON_W-1:0] smp, pin_en, pin_load, chg_vec;
  logic             chg_any;
  logic             port_lo_unused;

  assign port_lo_unused = ^port_in[MON_LO-1:0];

  pcd_sync #(.W(MON_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(port_in[PORT_W-1:MON_LO]), .q(smp)
  );

  pcd_detect #(.MON_W(MON_W)) u_detect (
    .clk(clk), .rst_n(rst_n), .smp(smp), .en(pin_en), .load(pin_load),
    .chg_vec(chg_vec), .chg_any(chg_any)
  );

  pcd_regs #(.PORT_W(PORT_W), .MON_LO(MON_LO)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .chg_any(chg_any),
    .pin_en(pin_en), .pin_load(pin_load), .irq_hi(irq_hi), .irq_lo(irq_lo)
  );

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_hi, irq_lo})); // R7
  AST_CHG_ON_EN: assert property (@(posedge clk) disable iff (!rst_n)
    chg_any |-> ((chg_vec & ~pin_en) == '0)); // R3
endmodule

// File: tb/test_port_change_irq.sv
`timescale 1ns/1ps
module test_port_change_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] port_in = '0;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_hi, irq_lo;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  port_change_irq i_port_change_irq (
    .clk(clk), .rst_n(rst_n), .port_in(port_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_hi(irq_hi), .irq_lo(irq_lo)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic a, logic [7:0] exp, string req);
    reg_addr = a;
    #1;
    check(req, {24'd0, reg_rdata}, {24'd0, exp});
  endtask

  task automatic flag_is(logic exp, string req);
    reg_addr = 1'b1;
    #1;
    check(req, {31'd0, reg_rdata[0]}, {31'd0, exp});
  endtask

  task automatic t_reset;
    rd(1'b0, 8'h00, "R9 pin enable reset");
    rd(1'b1, 8'h00, "R9 control reset");
    check("R9 irq reset", {30'd0, irq_hi, irq_lo}, 32'd0);
  endtask

  task automatic t_pinen_reg;
    wr(1'b0, 8'hFF);
    rd(1'b0, 8'hF0, "R4 low bits read zero");
    wr(1'b0, 8'h5A);
    rd(1'b0, 8'h50, "R4 readback");
    wr(1'b0, 8'hF0);
  endtask

  task automatic t_low_bits;
    port_in[3:0] = 4'hF; step(5);
    flag_is(1'b0, "R1 low bits rise ignored");
    port_in[3:0] = 4'h0; step(5);
    flag_is(1'b0, "R1 low bits fall ignored");
  endtask

  task automatic t_latency;
    port_in[5] = 1'b1; step(2);
    flag_is(1'b0, "R2 not yet set after two edges");
    step(1);
    flag_is(1'b1, "R2 set on third edge");
    wr(1'b1, 8'h01); step(1);
    flag_is(1'b0, "R5 cleared by write");
    port_in[5] = 1'b0; step(4);
    flag_is(1'b1, "R2 falling edge detected");
    step(6);
    flag_is(1'b1, "R5 flag sticky");
    wr(1'b1, 8'h01);
  endtask

  task automatic t_disabled;
    wr(1'b0, 8'h70);
    port_in[7] = 1'b1; step(5);
    flag_is(1'b0, "R3 disabled pin ignored");
  endtask

  task automatic t_enable_no_false;
    wr(1'b0, 8'hF0); step(5);
    flag_is(1'b0, "R8 enabling raises no change");
    port_in[7] = 1'b0; step(4);
    flag_is(1'b1, "R8 next real change reported");
  endtask

  task automatic t_set_wins;
    port_in[4] = 1'b1; step(2);
    wr(1'b1, 8'h01);
    flag_is(1'b1, "R5 set wins over clear");
    wr(1'b1, 8'h01);
    flag_is(1'b0, "R5 plain clear");
  endtask

  task automatic t_irq;
    port_in[6] = 1'b1; step(4);
    check("R6 no irq without port enable", {30'd0, irq_hi, irq_lo}, 32'd0);
    wr(1'b1, 8'h02);
    check("R7 low priority request", {30'd0, irq_hi, irq_lo}, 32'd1);
    wr(1'b1, 8'h06);
    check("R7 high priority request", {30'd0, irq_hi, irq_lo}, 32'd2);
    wr(1'b1, 8'h05);
    check("R6 enable cleared drops irq", {30'd0, irq_hi, irq_lo}, 32'd0);
    flag_is(1'b0, "R5 flag cleared");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_pinen_reg();
    t_low_bits();
    t_latency();
    t_disabled();
    t_enable_no_false();
    t_set_wins();
    t_irq();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule